// File: doc/BRIEF.md
# Pipelined Burst SRAM with Late Write

This block is a synchronous single-port memory whose 36-bit word is split into four 9-bit byte lanes. A command is sampled on one rising clock edge and its data moves during the following cycle: read data appears combinationally from the array in that cycle, and write data with its lane enables is taken at the next edge. Because a write commits at the same edge that samples the next command, reads and writes can alternate on every cycle with no idle slots, and a read issued right after a write sees the new contents.

A load command (load strobe low, chip selected) captures an address and an access direction. Advance cycles (load strobe high) ignore the address bus and step a 2-bit burst counter in the low address bits. The counter runs in linear order (wrapping increment) or interleaved order (start offset XOR beat number), chosen by a static input. An active-low clock enable freezes the whole block for an edge. A load with the chip deselected ends any burst, and the read drive drops in the next cycle. The bidirectional data bus is split into a write-data input, a read-data output and a drive-enable output that an asynchronous active-low output enable gates.

Top module: `pipe_burst_sram`

## Requirements
- R1: At an edge where cke_n, load_n, sel_a_n and sel_c_n are all low and sel_b is high, the block captures addr and is_read (1 = read, 0 = write). In the next cycle a read drives mem[addr] on rdata with rd_drive high.
- R2: At an enabled edge with load_n low and the chip deselected (sel_a_n high, sel_b low or sel_c_n high), the block performs no access in the next cycle: rd_drive and rdata are 0. Any burst in progress ends, so later advance cycles make no access either.
- R3: At an enabled edge with load_n high during a burst, addr and is_read are ignored. The upper address bits stay as loaded and only addr[1:0] steps.
- R4: With burst_xor low, beat n of a burst (n = 0..3) accesses low bits (start + n) mod 4, where start is addr[1:0] at the load.
- R5: With burst_xor high, beat n accesses low bits start XOR n.
- R6: Read data is flow-through, with no register after the array. A read in the cycle right after a write to the same word returns the newly written data.
- R7: Write data and lane_we_n are sampled at the edge after the write command. When lane_we_n[i] is 0, wdata[9i+8:9i] is written into lane i. When it is 1, lane i keeps its old value.
- R8: At an edge where cke_n is high, nothing changes. No command is taken, no write is done, and rdata and rd_drive keep their values. A pending write phase then takes its data at the next enabled edge.
- R9: When out_en_n is high, rd_drive and rdata are 0 right away, with no clock edge needed.
- R10: After reset the block is deselected with rd_drive low. Advance cycles with no burst in progress make no access.
- R11: rd_drive stays low during the data cycle of a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cke_n | input | 1 | Active-low clock enable; high freezes the block |
| load_n | input | 1 | Low loads a new command, high advances the burst |
| is_read | input | 1 | Access direction at load: 1 read, 0 write |
| sel_a_n | input | 1 | Active-low chip enable |
| sel_b | input | 1 | Active-high chip enable |
| sel_c_n | input | 1 | Second active-low chip enable |
| addr | input | ADDR_W | Word address, taken at load only |
| burst_xor | input | 1 | Static burst order: 1 interleaved, 0 linear |
| wdata | input | 36 | Write data, sampled one edge after the command |
| lane_we_n | input | 4 | Active-low per-lane write enables, sampled with wdata |
| out_en_n | input | 1 | Asynchronous active-low output enable |
| rdata | output | 36 | Flow-through read data; 0 when not driving |
| rd_drive | output | 1 | High when the block would drive the data bus |

## Verification
The hardest case to reach is one where the burst order actually matters. If a burst write and a burst read use the same wrong sequence, they agree with each other and hide the error. The bench therefore fills each 4-word group with single-word loads, checks a burst read against those loads, then burst-writes the group and reads it back with single loads. It does this for every start offset in both orders. Deliberately wrong addresses go on the bus during advance cycles. A second hard case is a write phase held open by a frozen clock enable. It is reached by presenting bogus data during the frozen edge and checking that only the data at the following enabled edge lands.

// File: rtl/pbs_pkg.sv
package pbs_pkg;

    localparam int LANES   = 4;
    localparam int LANE_W  = 9;
    localparam int WORD_W  = LANES * LANE_W;
    localparam int BURST_W = 2;

    typedef enum logic {
        OP_WRITE = 1'b0,
        OP_READ  = 1'b1
    } op_e;

    // State of the data phase that follows a command edge
    typedef struct packed {
        logic valid;
        op_e  op;
    } phase_t;

    typedef logic [BURST_W-1:0] boff_t;

    // Low address bits for a given beat of a burst
    function automatic boff_t burst_offset(boff_t start, boff_t beat, logic interleave);
        if (interleave)
            return start ^ beat;
        return boff_t'(start + beat);
    endfunction

endpackage

// File: rtl/pbs_burst_seq.sv
module pbs_burst_seq
    import pbs_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  logic  step,
    input  boff_t start,
    input  logic  interleave,
    output boff_t offset
);

    boff_t start_q;
    boff_t beat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= '0;
            beat_q  <= '0;
        end else if (load) begin
            start_q <= start;
            beat_q  <= '0;
        end else if (step) begin
            beat_q  <= boff_t'(beat_q + 1'b1);
        end
    end

    assign offset = burst_offset(start_q, beat_q, interleave);

    // R4
    linear_step_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !load && !interleave) |=> offset == boff_t'($past(offset) + 1'b1));

    // R5
    xor_step_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !load && interleave) |=>
            (offset ^ start_q) == boff_t'(($past(offset) ^ $past(start_q)) + 1'b1));

endmodule

// File: rtl/pbs_ctrl.sv
module pbs_ctrl
    import pbs_pkg::*;
#(
    parameter int UPPER_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               hold,
    input  logic               load_n,
    input  logic               is_read,
    input  logic               sel_a_n,
    input  logic               sel_b,
    input  logic               sel_c_n,
    input  logic [UPPER_W-1:0] upper_in,
    output logic               burst_load,
    output logic               burst_step,
    output logic [UPPER_W-1:0] upper_q,
    output logic               ph_valid,
    output logic               ph_read
);

    logic   selected;
    logic   active_q;
    phase_t ph_q;

    assign selected   = !sel_a_n && sel_b && !sel_c_n;
    assign burst_load = !hold && !load_n && selected;
    assign burst_step = !hold && load_n && active_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            upper_q  <= '0;
            ph_q     <= '{valid: 1'b0, op: OP_READ};
        end else if (!hold) begin
            if (!load_n) begin
                if (selected) begin
                    active_q   <= 1'b1;
                    upper_q    <= upper_in;
                    ph_q.valid <= 1'b1;
                    ph_q.op    <= is_read ? OP_READ : OP_WRITE;
                end else begin
                    active_q   <= 1'b0;
                    ph_q.valid <= 1'b0;
                end
            end else begin
                ph_q.valid <= active_q;
            end
        end
    end

    assign ph_valid = ph_q.valid;
    assign ph_read  = (ph_q.op == OP_READ);

    // R1
    load_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (!hold && !load_n && selected) |=>
            ph_valid && upper_q == $past(upper_in) && ph_read == $past(is_read));

    // R2
    deselect_chk: assert property (@(posedge clk) disable iff (rst)
        (!hold && !load_n && !selected) |=> !ph_valid && !active_q);

    // R10
    idle_advance_chk: assert property (@(posedge clk) disable iff (rst)
        (!hold && load_n && !active_q) |=> !ph_valid);

    // R3
    upper_fixed_chk: assert property (@(posedge clk) disable iff (rst)
        (!hold && load_n) |=> $stable(upper_q) && $stable(ph_read));

    // R8
    freeze_chk: assert property (@(posedge clk) disable iff (rst)
        hold |=> $stable(ph_valid) && $stable(active_q) && $stable(upper_q) && $stable(ph_read));

endmodule

// File: rtl/pbs_array.sv
module pbs_array
    import pbs_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [LANES-1:0]  lane_we_n,
    output logic [WORD_W-1:0] rword
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] store [DEPTH];

        always_ff @(posedge clk) begin
            if (we && !lane_we_n[g])
                store[addr] <= wdata[g*LANE_W +: LANE_W];
        end

        assign rword[g*LANE_W +: LANE_W] = store[addr];
    end

endmodule

// File: rtl/pipe_burst_sram.sv
module pipe_burst_sram
    import pbs_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cke_n,
    input  logic              load_n,
    input  logic              is_read,
    input  logic              sel_a_n,
    input  logic              sel_b,
    input  logic              sel_c_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              burst_xor,
    input  logic [35:0]       wdata,
    input  logic [3:0]        lane_we_n,
    input  logic              out_en_n,
    output logic [35:0]       rdata,
    output logic              rd_drive
);

    localparam int UPPER_W = ADDR_W - BURST_W;

    logic               hold;
    logic               burst_load;
    logic               burst_step;
    logic [UPPER_W-1:0] upper_q;
    logic               ph_valid;
    logic               ph_read;
    boff_t              offset;
    logic [ADDR_W-1:0]  ph_addr;
    logic               wr_fire;
    logic [WORD_W-1:0]  rword;

    assign hold = cke_n;

    pbs_ctrl #(.UPPER_W(UPPER_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .hold       (hold),
        .load_n     (load_n),
        .is_read    (is_read),
        .sel_a_n    (sel_a_n),
        .sel_b      (sel_b),
        .sel_c_n    (sel_c_n),
        .upper_in   (addr[ADDR_W-1:BURST_W]),
        .burst_load (burst_load),
        .burst_step (burst_step),
        .upper_q    (upper_q),
        .ph_valid   (ph_valid),
        .ph_read    (ph_read)
    );

    pbs_burst_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .load       (burst_load),
        .step       (burst_step),
        .start      (addr[BURST_W-1:0]),
        .interleave (burst_xor),
        .offset     (offset)
    );

    assign ph_addr = {upper_q, offset};
    assign wr_fire = ph_valid && !ph_read && !hold;

    pbs_array #(.ADDR_W(ADDR_W)) u_array (
        .clk       (clk),
        .we        (wr_fire),
        .addr      (ph_addr),
        .wdata     (wdata),
        .lane_we_n (lane_we_n),
        .rword     (rword)
    );

    assign rd_drive = ph_valid && ph_read && !out_en_n;
    assign rdata    = rd_drive ? rword : '0;

    // R9
    oe_gate_chk: assert property (@(posedge clk) disable iff (rst)
        out_en_n |-> (!rd_drive && rdata == '0));

    // R11
    write_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (ph_valid && !ph_read) |-> !rd_drive);

endmodule

// File: tb/pipe_burst_sram_bench.sv
module pipe_burst_sram_bench;

    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst;
    logic          cke_n, load_n, is_read, sel_a_n, sel_b, sel_c_n, burst_xor, out_en_n;
    logic [AW-1:0] addr;
    logic [35:0]   wdata;
    logic [3:0]    lane_we_n;
    logic [35:0]   rdata;
    logic          rd_drive;

    logic [35:0]   ref_mem [64];
    int            checks = 0;
    int            errors = 0;

    always #5 clk = ~clk;

    pipe_burst_sram #(.ADDR_W(AW)) u_pipe_burst_sram (
        .clk(clk), .rst(rst), .cke_n(cke_n), .load_n(load_n), .is_read(is_read),
        .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n), .addr(addr),
        .burst_xor(burst_xor), .wdata(wdata), .lane_we_n(lane_we_n),
        .out_en_n(out_en_n), .rdata(rdata), .rd_drive(rd_drive)
    );

    task automatic check(string req, logic [35:0] act, logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic cmd(logic ld, logic rd, int a);
        load_n  = ld;
        is_read = rd;
        addr    = AW'(a);
    endtask

    function automatic logic [35:0] pat(int a, int s);
        return {4'(s), 8'(a), 24'(a * 7919 + s * 104729 + 13)};
    endfunction

    function automatic int boff(int st, int n, int x);
        return (x != 0) ? (st ^ n) : ((st + n) & 3);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; cke_n = 1'b0; load_n = 1'b1; is_read = 1'b1;
        sel_a_n = 1'b0; sel_b = 1'b1; sel_c_n = 1'b0; burst_xor = 1'b0;
        out_en_n = 1'b0; addr = '0; wdata = '0; lane_we_n = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R10 reset drive", 36'(rd_drive), 36'd0);
        cmd(1, 1, 5);
        tick; check("R10 idle advance", 36'(rd_drive), 36'd0);
        tick; check("R10 idle advance", 36'(rd_drive), 36'd0);

        // Sweep both orders, two upper groups, all start offsets
        for (int x = 0; x < 2; x++) begin
            for (int u = 0; u < 2; u++) begin
                for (int st = 0; st < 4; st++) begin
                    int base;
                    int seed;
                    base = (x * 8 + u * 4 + st) * 4;
                    seed = x * 8 + u * 4 + st + 1;
                    burst_xor = x[0];
                    // single writes, then a burst read
                    for (int i = 0; i < 5; i++) begin
                        if (i < 4) cmd(0, 0, base + i);
                        else       cmd(0, 1, base + st);
                        if (i > 0) begin
                            wdata = pat(base + i - 1, seed);
                            ref_mem[base + i - 1] = wdata;
                        end
                        lane_we_n = '0;
                        tick;
                        if (i < 4) check("R11 write phase", 36'(rd_drive), 36'd0);
                        else begin
                            check("R6 read drive", 36'(rd_drive), 36'd1);
                            check("R1 load read", rdata, ref_mem[base + st]);
                        end
                    end
                    for (int n = 1; n < 4; n++) begin
                        cmd(1, 0, (base + 4 + n * 5) & 63);
                        wdata = 36'hBAD;
                        tick;
                        if (x != 0) check("R5 xor beat", rdata, ref_mem[base + boff(st, n, x)]);
                        else        check("R4 linear beat", rdata, ref_mem[base + boff(st, n, x)]);
                    end
                    // burst write, then single reads
                    cmd(0, 0, base + st);
                    tick;
                    for (int n = 1; n < 5; n++) begin
                        if (n < 4) cmd(1, 1, (base + 9 + n * 3) & 63);
                        else       cmd(0, 1, base);
                        wdata = pat(base + boff(st, n - 1, x), seed + 32);
                        ref_mem[base + boff(st, n - 1, x)] = wdata;
                        lane_we_n = '0;
                        tick;
                        if (n < 4) check("R11 burst write phase", 36'(rd_drive), 36'd0);
                        else       check("R3 burst write addr", rdata, ref_mem[base]);
                    end
                    for (int i = 1; i < 4; i++) begin
                        cmd(0, 1, base + i);
                        wdata = 36'h123;
                        tick;
                        check("R3 burst write addr", rdata, ref_mem[base + i]);
                    end
                end
            end
        end

        // Lane enable sweep, read right after each write
        burst_xor = 1'b0;
        for (int m = 0; m < 16; m++) begin
            logic [3:0] mk;
            mk = 4'(m);
            cmd(0, 0, 9);
            tick;
            cmd(0, 1, 9);
            wdata = pat(9, m + 100);
            lane_we_n = mk;
            for (int g = 0; g < 4; g++)
                if (!mk[g]) ref_mem[9][g*9 +: 9] = wdata[g*9 +: 9];
            tick;
            check("R7 lane mask", rdata, ref_mem[9]);
        end
        lane_we_n = '0;

        // Deselect through each chip enable
        for (int k = 0; k < 3; k++) begin
            cmd(0, 1, 9);
            tick;
            check("R1 selected read", 36'(rd_drive), 36'd1);
            sel_a_n = (k == 0); sel_b = (k != 1); sel_c_n = (k == 2);
            tick;
            check("R2 deselect drive", 36'(rd_drive), 36'd0);
            check("R2 deselect data", rdata, 36'd0);
            sel_a_n = 1'b0; sel_b = 1'b1; sel_c_n = 1'b0;
            cmd(1, 1, 9);
            tick;
            check("R2 burst ended", 36'(rd_drive), 36'd0);
        end

        // Clock enable freeze
        cmd(0, 1, 9);
        tick;
        check("R8 before freeze", rdata, ref_mem[9]);
        cke_n = 1'b1;
        cmd(0, 1, 20);
        tick;
        check("R8 frozen data", rdata, ref_mem[9]);
        check("R8 frozen drive", 36'(rd_drive), 36'd1);
        cke_n = 1'b0;
        cmd(0, 0, 30);
        tick;
        cke_n = 1'b1;
        wdata = 36'hDEAD_BEEF;
        cmd(0, 1, 31);
        tick;
        check("R8 frozen write phase", 36'(rd_drive), 36'd0);
        cke_n = 1'b0;
        wdata = pat(30, 200);
        ref_mem[30] = wdata;
        cmd(0, 1, 30);
        tick;
        check("R8 held write data", rdata, ref_mem[30]);

        // Asynchronous output enable
        cmd(1, 1, 0);
        out_en_n = 1'b1;
        #1;
        check("R9 oe drive", 36'(rd_drive), 36'd0);
        check("R9 oe data", rdata, 36'd0);
        out_en_n = 1'b0;
        #1;
        check("R9 oe restore", rdata, ref_mem[30]);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule